// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the software-visible register file of one bus-master storage DMA channel. A host reaches it through a byte-addressable I/O port. The port selects one of three registers: command, status or descriptor-table base. The block turns command writes into start requests for a separate DMA engine. It also hands that engine the table pointer to begin from, and it accepts the engine's completion report. The engine's descriptor walking and the disk command logic live elsewhere.

The start bit acts only when its value changes. Setting it reloads the working table pointer from the base register and, if the channel is idle, starts the engine. Clearing it never aborts a transfer in flight: the channel stays active until the engine reports completion. The base register accepts 1-, 2- or 4-byte accesses at any byte offset, and its two lowest bits always read as zero. The drive's interrupt line is forwarded to the output unchanged, and each rising edge on it also sets a sticky interrupt flag in status.

Top module: `bmdma_regs`

## Requirements
- R1: After a cycle with `rst_n` low, command, status, base and `cur_ptr` read zero, `eng_start` and `unit_valid` are low, and an active transfer is cancelled.
- R2: A command write stores only bits 0 (start) and 3 (direction) of the written byte, so a command read returns the written byte ANDed with 0x09. `dir_out` follows bit 3.
- R3: A command write whose bit 0 changes start from 0 to 1 copies the base register into `cur_ptr`. If the status active bit (bit 0) was clear, the same write sets that bit and raises `eng_start` for exactly one cycle, the cycle after the write.
- R4: A command write that leaves bit 0 at its stored value causes no `eng_start` and leaves `cur_ptr` unchanged, even if the base register has changed since.
- R5: A command write that changes start from 1 to 0 leaves the status active bit set.
- R6: A 0-to-1 start change while the active bit is already set reloads `cur_ptr` but produces no `eng_start`.
- R7: A base write (register code 2) with size code 0, 1 or 2 (1, 2 or 4 bytes) at byte offset `io_off` changes only the addressed bytes, which take the low bytes of `io_wdata`. Lanes past byte 3 are dropped, and bits 1:0 of the base are always zero.
- R8: A base read returns the base register shifted right by 8×`io_off` and masked to the access width.
- R9: `irq_out` equals `drv_irq` at all times. A rising edge of `drv_irq` sets status bit 2, and that setting wins over a clear of bit 2 made in the same cycle.
- R10: A status write (register code 1) clears bit 1 or bit 2 where the written byte has a 1. Status bit 0 (active) ignores status writes.
- R11: An `eng_done` pulse clears the active bit and `unit_valid`. If `eng_err` is high with it, status bit 1 is set.
- R12: A `unit_we` pulse records the one-bit `unit_val` on `unit_id` and sets `unit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | I/O access valid this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_reg | input | 2 | Register code: 0 command, 1 status, 2 base, 3 none |
| io_off | input | 2 | Byte offset within the register |
| io_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, other = 4 bytes |
| io_wdata | input | 32 | Write data, byte-aligned to the offset |
| io_rdata | output | 32 | Read data for the selected register |
| eng_start | output | 1 | One-cycle start request to the DMA engine |
| cur_ptr | output | 32 | Descriptor table pointer for the engine |
| dir_out | output | 1 | Transfer direction (command bit 3) |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Error qualifier for `eng_done` |
| unit_we | input | 1 | Record the active drive unit |
| unit_val | input | 1 | Drive unit number |
| unit_valid | output | 1 | A drive unit is selected |
| unit_id | output | 1 | Selected drive unit |
| drv_irq | input | 1 | Drive interrupt level |
| irq_out | output | 1 | Forwarded interrupt level |

## Verification
Two pairs of events can land on the same clock edge. In the first, a rising drive interrupt meets a software write that clears the interrupt flag. The bench drives both in one cycle and expects the flag to read set afterwards. In the second, a start request meets an engine completion while the channel is idle. The bench expects the start to win: the active bit reads set and one start pulse carries the reloaded pointer.

// File: rtl/bmdma_pkg.sv
// Shared codes for the bus-master DMA control registers.
// Assumes a single-channel register port with 2-bit register selection.
package bmdma_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BASE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int          GO_BIT   = 0;
    localparam int          DIR_BIT  = 3;
    localparam logic [7:0]  CMD_KEEP = 8'h09;

    localparam int          ST_ACT = 0;
    localparam int          ST_ERR = 1;
    localparam int          ST_IRQ = 2;

    // Byte count for an access size code
    function automatic int size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/bmdma_base_reg.sv
// Descriptor-table base register with byte-lane partial writes and
// shifted, width-masked reads. Assumes ADDR_W is a multiple of 8.
// The two lowest bits are held at zero.
module bmdma_base_reg
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int NBYTES = ADDR_W / 8,
    localparam int OFF_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] rd_data
);
    logic [NBYTES-1:0] lane_en;
    logic [ADDR_W-1:0] wshift;
    logic [ADDR_W-1:0] rd_mask;

    // Which byte lanes the current access covers, and the aligned write data
    always_comb begin
        wshift = wdata << {off, 3'b000};
        for (int b = 0; b < NBYTES; b++) begin
            lane_en[b]        = wr_en && (b >= int'(off)) && (b < int'(off) + size_bytes(size));
            rd_mask[8*b +: 8] = (b < size_bytes(size)) ? 8'hFF : 8'h00;
        end
    end

    // One flop group per byte lane; lane 0 keeps bits 1:0 at zero
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[8*g +: 8] <= 8'h00;
            else if (lane_en[g])
                base_q[8*g +: 8] <= (g == 0) ? (wshift[8*g +: 8] & 8'hFC) : wshift[8*g +: 8];
        end
    end

    // Read path: shift the addressed byte down and mask to the width
    assign rd_data = (base_q >> {off, 3'b000}) & rd_mask;

    p_base_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[1:0] == 2'b00)
        else $error("base low bits nonzero");
endmodule

// File: rtl/bmdma_cmd_stat.sv
// Command and status registers plus the engine handshake.
// A start change 0->1 reloads the pointer and starts an idle engine;
// a change 1->0 leaves the transfer running until the engine finishes.
// Assumes eng_done is a single-cycle pulse.
module bmdma_cmd_stat
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              stat_we,
    input  logic [7:0]        wbyte,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              drv_irq,
    input  logic              unit_we,
    input  logic              unit_val,
    output logic [7:0]        cmd_q,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              eng_start,
    output logic              unit_valid,
    output logic              unit_id
);
    logic active, err_flag, irq_flag, irq_prev;
    logic go_rise, go_same, irq_rise;

    assign go_same  = cmd_we && (wbyte[GO_BIT] == cmd_q[GO_BIT]);
    assign go_rise  = cmd_we && wbyte[GO_BIT] && !cmd_q[GO_BIT];
    assign irq_rise = drv_irq && !irq_prev;

    // Command register keeps only start and direction
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 8'h00;
        else if (cmd_we) cmd_q <= wbyte & CMD_KEEP;
    end

    // Working table pointer reloads on a start rise
    always_ff @(posedge clk) begin
        if (!rst_n) cur_ptr <= '0;
        else if (go_rise) cur_ptr <= base_q;
    end

    // Active flag and one-cycle start request to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            eng_start <= 1'b0;
        end else begin
            active    <= (active && !eng_done) || (go_rise && !active);
            eng_start <= go_rise && !active;
        end
    end

    // Sticky error and interrupt flags, write-one-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            irq_flag <= 1'b0;
            irq_prev <= 1'b0;
        end else begin
            irq_prev <= drv_irq;
            err_flag <= (eng_done && eng_err) || (err_flag && !(stat_we && wbyte[ST_ERR]));
            irq_flag <= irq_rise || (irq_flag && !(stat_we && wbyte[ST_IRQ]));
        end
    end

    // Active drive unit: recorded on select, dropped on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_valid <= 1'b0;
            unit_id    <= 1'b0;
        end else if (eng_done) begin
            unit_valid <= 1'b0;
        end else if (unit_we) begin
            unit_valid <= 1'b1;
            unit_id    <= unit_val;
        end
    end

    assign stat_q = {5'b00000, irq_flag, err_flag, active};

    p_go_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> stat_q[ST_ACT])
        else $error("start pulse without active");
    p_go_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (cur_ptr == base_q))
        else $error("start pulse with stale pointer");
    p_no_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go_same |=> (!eng_start && $stable(cur_ptr)))
        else $error("unchanged start had an effect");
    p_no_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[ST_ACT] && !eng_done) |=> stat_q[ST_ACT])
        else $error("active dropped without completion");
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[ST_ACT] && eng_done) |=> (!stat_q[ST_ACT] && !unit_valid))
        else $error("completion did not idle the channel");
    p_irq_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> stat_q[ST_IRQ])
        else $error("interrupt edge not latched");
endmodule

// File: rtl/bmdma_regs.sv
// Top of the bus-master DMA control registers: decodes the I/O port,
// muxes read data and forwards the drive interrupt level.
// Assumes one access per cycle; reads have no side effects.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int NBYTES = ADDR_W / 8,
    localparam int OFF_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [1:0]        io_reg,
    input  logic [OFF_W-1:0]  io_off,
    input  logic [1:0]        io_size,
    input  logic [ADDR_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] io_rdata,
    output logic              eng_start,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              dir_out,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              unit_we,
    input  logic              unit_val,
    output logic              unit_valid,
    output logic              unit_id,
    input  logic              drv_irq,
    output logic              irq_out
);
    reg_sel_e          sel;
    logic              cmd_we, stat_we, base_we;
    logic [7:0]        cmd_q, stat_q;
    logic [ADDR_W-1:0] base_q, base_rd;

    assign sel     = reg_sel_e'(io_reg);
    assign cmd_we  = io_sel && io_wr && (sel == SEL_CMD);
    assign stat_we = io_sel && io_wr && (sel == SEL_STAT);
    assign base_we = io_sel && io_wr && (sel == SEL_BASE);

    bmdma_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_we),
        .off     (io_off),
        .size    (io_size),
        .wdata   (io_wdata),
        .base_q  (base_q),
        .rd_data (base_rd)
    );

    bmdma_cmd_stat #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .stat_we    (stat_we),
        .wbyte      (io_wdata[7:0]),
        .base_q     (base_q),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .drv_irq    (drv_irq),
        .unit_we    (unit_we),
        .unit_val   (unit_val),
        .cmd_q      (cmd_q),
        .stat_q     (stat_q),
        .cur_ptr    (cur_ptr),
        .eng_start  (eng_start),
        .unit_valid (unit_valid),
        .unit_id    (unit_id)
    );

    // Read mux for the selected register
    always_comb begin
        io_rdata = '0;
        if (io_sel && !io_wr) begin
            case (sel)
                SEL_CMD:  io_rdata = {{(ADDR_W-8){1'b0}}, cmd_q};
                SEL_STAT: io_rdata = {{(ADDR_W-8){1'b0}}, stat_q};
                SEL_BASE: io_rdata = base_rd;
                default:  io_rdata = '0;
            endcase
        end
    end

    assign dir_out = cmd_q[DIR_BIT];
    assign irq_out = drv_irq;
endmodule

// File: tb/sim_bmdma_regs.sv
module sim_bmdma_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, io_wr = 1'b0;
    logic [1:0]  io_reg = 2'd3, io_off = 2'd0, io_size = 2'd0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata, cur_ptr;
    logic        eng_start, dir_out, unit_valid, unit_id, irq_out;
    logic        eng_done = 1'b0, eng_err = 1'b0, unit_we = 1'b0, unit_val = 1'b0;
    logic        drv_irq = 1'b0;

    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] rv;

    always #(CLK_P/2) clk = ~clk;

    bmdma_regs u0 (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_reg(io_reg),
        .io_off(io_off), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .eng_start(eng_start), .cur_ptr(cur_ptr), .dir_out(dir_out),
        .eng_done(eng_done), .eng_err(eng_err), .unit_we(unit_we), .unit_val(unit_val),
        .unit_valid(unit_valid), .unit_id(unit_id), .drv_irq(drv_irq), .irq_out(irq_out)
    );

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic io_write(input logic [1:0] r, input logic [1:0] off,
                            input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        io_sel = 1'b1; io_wr = 1'b1; io_reg = r; io_off = off; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [1:0] r, input logic [1:0] off,
                           input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        io_sel = 1'b1; io_wr = 1'b0; io_reg = r; io_off = off; io_size = sz;
        #1 d = io_rdata;
        io_sel = 1'b0;
    endtask

    // Monitor: every start pulse must match the next expected pointer
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R4/R6 unexpected start pulse: got ptr %h expected none", cur_ptr);
            end else begin
                chk("R3 start pointer", cur_ptr, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        io_read(2'd0, 2'd0, 2'd2, rv); chk("R1 cmd", rv, 32'h0);
        io_read(2'd1, 2'd0, 2'd2, rv); chk("R1 status", rv, 32'h0);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R1 base", rv, 32'h0);
        chk("R1 outputs", {eng_start, unit_valid, irq_out, dir_out}, 32'h0);
        chk("R1 cur_ptr", cur_ptr, 32'h0);

        // R7/R8: base partial accesses
        io_write(2'd2, 2'd0, 2'd2, 32'h1234_5677);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R7 full write low bits", rv, 32'h1234_5674);
        io_read(2'd2, 2'd1, 2'd0, rv); chk("R8 byte read off1", rv, 32'h56);
        io_read(2'd2, 2'd2, 2'd1, rv); chk("R8 half read off2", rv, 32'h1234);
        io_write(2'd2, 2'd0, 2'd0, 32'h0000_00FF);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R7 byte write off0", rv, 32'h1234_56FC);
        io_write(2'd2, 2'd1, 2'd1, 32'h0000_ABCD);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R7 half write off1", rv, 32'h12AB_CDFC);
        io_write(2'd2, 2'd2, 2'd2, 32'h9988_7766);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R7 word write off2", rv, 32'h7766_CDFC);
        io_read(2'd2, 2'd3, 2'd0, rv); chk("R8 byte read off3", rv, 32'h77);

        // R2/R3: start from idle
        exp_q.push_back(32'h7766_CDFC);
        io_write(2'd0, 2'd0, 2'd0, 32'h0000_00FF);
        io_read(2'd0, 2'd0, 2'd0, rv); chk("R2 cmd mask", rv, 32'h09);
        chk("R2 dir_out", {31'b0, dir_out}, 32'h1);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R3 active set", rv, 32'h01);
        chk("R3 pulse seen", exp_q.size(), 32'h0);

        // R4: same start value, base changed meanwhile
        io_write(2'd2, 2'd0, 2'd2, 32'h0000_1000);
        io_write(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        @(negedge clk);
        chk("R4 pointer unchanged", cur_ptr, 32'h7766_CDFC);
        io_read(2'd0, 2'd0, 2'd0, rv); chk("R4 dir updated", rv, 32'h01);

        // R5: clearing start does not abort
        io_write(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R5 still active", rv, 32'h01);

        // R6: start again while active reloads without a pulse
        io_write(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        @(negedge clk);
        chk("R6 pointer reloaded", cur_ptr, 32'h0000_1000);

        // R10: active bit ignores status writes
        io_write(2'd1, 2'd0, 2'd0, 32'h0000_0001);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R10 active read-only", rv, 32'h01);

        // R12: unit select
        @(negedge clk); unit_we = 1'b1; unit_val = 1'b1;
        @(negedge clk); unit_we = 1'b0;
        chk("R12 unit", {30'b0, unit_valid, unit_id}, 32'h3);

        // R11: completion with error
        @(negedge clk); eng_done = 1'b1; eng_err = 1'b1;
        @(negedge clk); eng_done = 1'b0; eng_err = 1'b0;
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R11 idle with error", rv, 32'h02);
        chk("R11 unit none", {31'b0, unit_valid}, 32'h0);
        io_write(2'd1, 2'd0, 2'd0, 32'h0000_0002);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R10 error cleared", rv, 32'h00);

        // R9: interrupt latch and pass-through
        @(negedge clk); drv_irq = 1'b1; #1 chk("R9 irq high forwarded", {31'b0, irq_out}, 32'h1);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R9 flag set", rv, 32'h04);
        @(negedge clk); drv_irq = 1'b0; #1 chk("R9 irq low forwarded", {31'b0, irq_out}, 32'h0);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R9 flag sticky", rv, 32'h04);
        io_write(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R10 irq cleared", rv, 32'h00);

        // R9: rising edge and clear in the same cycle; set wins
        @(negedge clk);
        drv_irq = 1'b1; io_sel = 1'b1; io_wr = 1'b1; io_reg = 2'd1; io_wdata = 32'h4;
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0;
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R9 set beats clear", rv, 32'h04);
        drv_irq = 1'b0;
        io_write(2'd1, 2'd0, 2'd0, 32'h0000_0004);

        // R3/R11: start and completion in one cycle while idle; start wins
        io_write(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        exp_q.push_back(32'h0000_1000);
        @(negedge clk);
        io_sel = 1'b1; io_wr = 1'b1; io_reg = 2'd0; io_wdata = 32'h1; eng_done = 1'b1;
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0; eng_done = 1'b0;
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R3 start beats idle completion", rv, 32'h01);
        chk("R3 collision pulse seen", exp_q.size(), 32'h0);

        // R1: reset while active
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        io_read(2'd1, 2'd0, 2'd0, rv); chk("R1 status after reset", rv, 32'h0);
        io_read(2'd0, 2'd0, 2'd0, rv); chk("R1 cmd after reset", rv, 32'h0);
        io_read(2'd2, 2'd0, 2'd2, rv); chk("R1 base after reset", rv, 32'h0);
        chk("R1 cur_ptr after reset", cur_ptr, 32'h0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule